// File: doc/BRIEF.md
# Upper Memory Shadow Access Router

This block steers each memory cycle in the top 256KB of the first megabyte (C0000h to FFFFFh) to one of three targets: local DRAM that holds a shadow copy, the BIOS ROM chip-select, or the expansion bus. It can also suppress a write when the area is write-protected. The decision uses the cycle address, a read/write flag and a set of static shadow control fields. The C, D and E areas are shadowed in 16KB slices. The D and E areas each have a 64KB master enable and a write-protect bit. The C area has a write-protect bit and a copy mode. The F area has a BIOS mode bit that chooses between running the BIOS from ROM and running it from a protected DRAM copy.

A read and a write to the same address can go to different targets. This lets firmware copy ROM or bus contents into shadow DRAM: it reads from the original source and writes into DRAM. Once the copy is done, it locks the DRAM copy against writes. Each accepted cycle produces a result one clock later. That result is exactly one select strobe, or the write-inhibit flag alone. An idle clock produces nothing.

Top module: `shadow_router`

## Requirements
- R1: While reset is held low at a clock edge, all four outputs (`sel_dram`, `sel_rom`, `sel_bus`, `wr_inhibit`) are 0 after that edge.
- R2: The result of a cycle presented with `cyc_valid`=1 appears on the clock edge that samples it. Exactly one of the four outputs is high for each such cycle. All four outputs are 0 after an edge where `cyc_valid` is 0.
- R3: An address with bits [19:18] not equal to 2'b11 is outside the window and is routed to the bus, for reads and for writes.
- R4: Inside the window, address bits [17:16] select the area: 00=C, 01=D, 10=E, 11=F. Bits [15:14] select the 16KB slice, and slice n is controlled by bit n of that area's slice mask. A C slice whose mask bit is set sends both reads and writes to DRAM (copy mode off, no protect). A C slice whose mask bit is clear goes to the bus.
- R5: With `c_wprot`=1, a write to a shadowed C slice raises `wr_inhibit` and selects nothing. Reads are unaffected.
- R6: With `c_copy`=1, a read from a shadowed C slice goes to the bus and a write goes to DRAM. Protect still takes priority over the write.
- R7: A D slice is shadowed only when `d_area_on` and its slice bit are both 1. A shadowed D slice reads from DRAM and writes to DRAM, unless `d_wprot`=1, in which case the write is inhibited. An unshadowed D slice goes to the bus.
- R8: With `e_area_on`=0, every E-area access, read or write, selects ROM, whatever the slice mask holds.
- R9: With `e_area_on`=1, a shadowed E slice behaves like a shadowed D slice under `e_wprot`, and an E slice whose mask bit is clear goes to the bus.
- R10: With `bios_from_rom`=1, F-area reads select ROM and F-area writes select DRAM.
- R11: With `bios_from_rom`=0, F-area reads select DRAM and F-area writes are inhibited, so ROM is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | A memory cycle is presented this clock |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_addr | input | 20 | Byte address of the cycle |
| c_slice_en | input | 4 | C area 16KB shadow enables |
| c_wprot | input | 1 | C area shadow write protect |
| c_copy | input | 1 | C area copy mode (read bus, write DRAM) |
| d_area_on | input | 1 | D area 64KB shadow enable |
| d_slice_en | input | 4 | D area 16KB shadow enables |
| d_wprot | input | 1 | D area write protect |
| e_area_on | input | 1 | E area 64KB shadow enable (0 = ROM owns E area) |
| e_slice_en | input | 4 | E area 16KB shadow enables |
| e_wprot | input | 1 | E area write protect |
| bios_from_rom | input | 1 | F area mode: 1 = read ROM/write DRAM, 0 = read DRAM/protected |
| sel_dram | output | 1 | Registered strobe: cycle goes to DRAM |
| sel_rom | output | 1 | Registered strobe: ROM chip-select |
| sel_bus | output | 1 | Registered strobe: cycle goes to expansion bus |
| wr_inhibit | output | 1 | Registered flag: write suppressed by protection |

## Verification
Copy mode and write protection can both act on the same write to a shadowed C slice. One rule sends the write to DRAM and the other blocks it. The bench sets `c_copy` and `c_wprot` together and checks that the write raises only `wr_inhibit` while a read in the same setup still goes to the bus. A second overlap uses the E area: the slice mask is set while the area enable is off. The bench judges that the area enable wins, so the access goes to ROM and not to DRAM.

// File: rtl/shadow_pkg.sv
// Package: shared types for the upper-memory shadow router.
// Assumes a 2-bit area field and a 2-bit slice field inside a 256KB window.
package shadow_pkg;

    // Target chosen for one cycle; TGT_INHIBIT means the write is dropped.
    typedef enum logic [1:0] {
        TGT_DRAM    = 2'd0,
        TGT_ROM     = 2'd1,
        TGT_BUS     = 2'd2,
        TGT_INHIBIT = 2'd3
    } route_t;

    // 64KB area selected by the address inside the window.
    typedef enum logic [1:0] {
        AREA_C = 2'd0,
        AREA_D = 2'd1,
        AREA_E = 2'd2,
        AREA_F = 2'd3
    } area_t;

endpackage

// File: rtl/shadow_decode.sv
// Module: shadow_decode
// Splits a cycle address into window hit, 64KB area and 16KB slice.
// Assumes the window is the top quarter of the address space, split into
// four areas of four slices each.
module shadow_decode
    import shadow_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int SLICE_W = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               in_window,
    output area_t              area,
    output logic [SLICE_W-1:0] slice
);
    localparam int TOP   = ADDR_W - 1;
    localparam int AREA_HI = ADDR_W - 3;
    localparam int SLICE_HI = ADDR_W - 5;

    // Field extraction from the upper address bits.
    always_comb begin
        in_window = &addr[TOP -: 2];
        area      = area_t'(addr[AREA_HI -: 2]);
        slice     = addr[SLICE_HI -: SLICE_W];
    end
endmodule

// File: rtl/shadow_policy.sv
// Module: shadow_policy
// Combinational routing rules: maps area, slice, direction and the shadow
// controls to a single target. Assumes controls are static during a cycle.
module shadow_policy
    import shadow_pkg::*;
#(
    parameter int SLICES  = 4,
    localparam int SLICE_W = $clog2(SLICES)
) (
    input  logic               in_window,
    input  area_t              area,
    input  logic [SLICE_W-1:0] slice,
    input  logic               is_write,
    input  logic [SLICES-1:0]  c_slice_en,
    input  logic               c_wprot,
    input  logic               c_copy,
    input  logic               d_area_on,
    input  logic [SLICES-1:0]  d_slice_en,
    input  logic               d_wprot,
    input  logic               e_area_on,
    input  logic [SLICES-1:0]  e_slice_en,
    input  logic               e_wprot,
    input  logic               bios_from_rom,
    output route_t             route
);
    logic c_hit, d_hit, e_hit;

    // Per-slice shadow state of each area, gated by its 64KB enable.
    always_comb begin
        c_hit = c_slice_en[slice];
        d_hit = d_area_on & d_slice_en[slice];
        e_hit = e_area_on & e_slice_en[slice];
    end

    // Shadowed slice with a protect bit: read from DRAM, write to DRAM or drop.
    function automatic route_t shadow_rw(input logic wr, input logic wp);
        if (wr && wp) return TGT_INHIBIT;
        return TGT_DRAM;
    endfunction

    // Target selection; unclaimed cycles fall through to the bus.
    always_comb begin
        route = TGT_BUS;
        if (in_window) begin
            unique case (area)
                AREA_C: begin
                    if (c_hit) begin
                        if (is_write)    route = shadow_rw(1'b1, c_wprot);
                        else if (c_copy) route = TGT_BUS;
                        else             route = TGT_DRAM;
                    end
                end
                AREA_D: begin
                    if (d_hit) route = shadow_rw(is_write, d_wprot);
                end
                AREA_E: begin
                    if (!e_area_on) route = TGT_ROM;
                    else if (e_hit) route = shadow_rw(is_write, e_wprot);
                end
                AREA_F: begin
                    if (bios_from_rom) route = is_write ? TGT_DRAM : TGT_ROM;
                    else               route = is_write ? TGT_INHIBIT : TGT_DRAM;
                end
                default: route = TGT_BUS;
            endcase
        end
    end
endmodule

// File: rtl/shadow_router.sv
// Module: shadow_router (top)
// Routes each upper-memory cycle to DRAM, ROM or the expansion bus, or
// suppresses a protected write. Results are registered: one strobe (or the
// inhibit flag) for one clock after each valid cycle.
// Assumes the control inputs change only between cycles.
module shadow_router
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SLICES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [SLICES-1:0] c_slice_en,
    input  logic              c_wprot,
    input  logic              c_copy,
    input  logic              d_area_on,
    input  logic [SLICES-1:0] d_slice_en,
    input  logic              d_wprot,
    input  logic              e_area_on,
    input  logic [SLICES-1:0] e_slice_en,
    input  logic              e_wprot,
    input  logic              bios_from_rom,
    output logic              sel_dram,
    output logic              sel_rom,
    output logic              sel_bus,
    output logic              wr_inhibit
);
    localparam int SLICE_W = $clog2(SLICES);
    localparam int N_OUT   = 4;

    logic               in_window;
    area_t              area;
    logic [SLICE_W-1:0] slice;
    route_t             route;
    logic [N_OUT-1:0]   onehot_d, onehot_q;

    shadow_decode #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_decode (
        .addr      (cyc_addr),
        .in_window (in_window),
        .area      (area),
        .slice     (slice)
    );

    shadow_policy #(.SLICES(SLICES)) u_policy (
        .in_window     (in_window),
        .area          (area),
        .slice         (slice),
        .is_write      (cyc_write),
        .c_slice_en    (c_slice_en),
        .c_wprot       (c_wprot),
        .c_copy        (c_copy),
        .d_area_on     (d_area_on),
        .d_slice_en    (d_slice_en),
        .d_wprot       (d_wprot),
        .e_area_on     (e_area_on),
        .e_slice_en    (e_slice_en),
        .e_wprot       (e_wprot),
        .bios_from_rom (bios_from_rom),
        .route         (route)
    );

    // Expand the route code into one output line per target.
    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_expand
            assign onehot_d[i] = cyc_valid && (route == route_t'(i));
        end
    endgenerate

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) onehot_q <= '0;
        else        onehot_q <= onehot_d;
    end

    assign sel_dram   = onehot_q[TGT_DRAM];
    assign sel_rom    = onehot_q[TGT_ROM];
    assign sel_bus    = onehot_q[TGT_BUS];
    assign wr_inhibit = onehot_q[TGT_INHIBIT];

    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_dram, sel_rom, sel_bus, wr_inhibit}) <= 1); // R2
    AST_VALID_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> (sel_dram || sel_rom || sel_bus || wr_inhibit)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> !(sel_dram || sel_rom || sel_bus || wr_inhibit)); // R2
    AST_INHIBIT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_write) |=> !wr_inhibit); // R5
    AST_OUTSIDE_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !(&cyc_addr[ADDR_W-1 -: 2])) |=> sel_bus); // R3
    AST_F_WRITE_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_write && (&cyc_addr[ADDR_W-1 -: 4])) |=> !sel_rom); // R10
    AST_E_OFF_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !e_area_on && (cyc_addr[ADDR_W-1 -: 4] == 4'b1110)) |=> sel_rom); // R8
endmodule

// File: tb/shadow_router_test.sv
module shadow_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0, cyc_write = 1'b0;
    logic [19:0] cyc_addr = '0;
    logic [3:0]  c_slice_en = '0, d_slice_en = '0, e_slice_en = '0;
    logic        c_wprot = 0, c_copy = 0, d_area_on = 0, d_wprot = 0;
    logic        e_area_on = 0, e_wprot = 0, bios_from_rom = 0;
    logic        sel_dram, sel_rom, sel_bus, wr_inhibit;
    int          checks = 0, errors = 0;
    bit          done = 0;

    localparam logic [3:0] EXP_DRAM = 4'b0001, EXP_ROM = 4'b0010,
                           EXP_BUS = 4'b0100, EXP_INH = 4'b1000, EXP_NONE = 4'b0000;

    always #2 clk = ~clk;

    shadow_router uut (.*);

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {wr_inhibit, sel_bus, sel_rom, sel_dram};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {inh,bus,rom,dram}=%b expected %b", req, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, result sampled at the next falling edge.
    task automatic run(input logic [19:0] a, input logic wr, input string req,
                       input logic [3:0] exp);
        @(negedge clk);
        cyc_addr = a; cyc_write = wr; cyc_valid = 1'b1;
        @(negedge clk);
        cyc_valid = 1'b0;
        check(req, exp);
    endtask

    task automatic t_reset();
        @(negedge clk); check("R1", EXP_NONE);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); check("R2 idle", EXP_NONE);
    endtask

    task automatic t_outside();
        c_slice_en = 4'hF; d_area_on = 1; d_slice_en = 4'hF;
        run(20'h80000, 0, "R3", EXP_BUS);
        run(20'h0C000, 1, "R3", EXP_BUS);
        c_slice_en = 0; d_area_on = 0; d_slice_en = 0;
    endtask

    task automatic t_c_area();
        c_slice_en = 4'b0100;
        run(20'hC8123, 0, "R4", EXP_DRAM);
        run(20'hC8123, 1, "R4", EXP_DRAM);
        run(20'hC4000, 0, "R4", EXP_BUS);
        c_wprot = 1;
        run(20'hC9000, 1, "R5", EXP_INH);
        run(20'hC9000, 0, "R5", EXP_DRAM);
        run(20'hCC000, 1, "R5", EXP_BUS);
        c_wprot = 0; c_copy = 1;
        run(20'hC8000, 0, "R6", EXP_BUS);
        run(20'hC8000, 1, "R6", EXP_DRAM);
        c_wprot = 1;
        run(20'hC8000, 1, "R6 protect wins", EXP_INH);
        run(20'hC8000, 0, "R6 read with protect", EXP_BUS);
        c_wprot = 0; c_copy = 0; c_slice_en = 0;
    endtask

    task automatic t_d_area();
        d_slice_en = 4'b1000;
        run(20'hDC000, 0, "R7 area off", EXP_BUS);
        d_area_on = 1;
        run(20'hDFFFF, 0, "R7", EXP_DRAM);
        run(20'hDC010, 1, "R7", EXP_DRAM);
        run(20'hD0000, 0, "R7 slice off", EXP_BUS);
        d_wprot = 1;
        run(20'hDC010, 1, "R7 protect", EXP_INH);
        d_wprot = 0; d_area_on = 0; d_slice_en = 0;
    endtask

    task automatic t_e_area();
        e_slice_en = 4'b0001;
        run(20'hE0000, 0, "R8", EXP_ROM);
        run(20'hE0000, 1, "R8", EXP_ROM);
        run(20'hEC000, 0, "R8", EXP_ROM);
        e_area_on = 1;
        run(20'hE2000, 0, "R9", EXP_DRAM);
        run(20'hE2000, 1, "R9", EXP_DRAM);
        run(20'hE4000, 0, "R9 slice off", EXP_BUS);
        e_wprot = 1;
        run(20'hE2000, 1, "R9 protect", EXP_INH);
        e_wprot = 0; e_area_on = 0; e_slice_en = 0;
    endtask

    task automatic t_f_area();
        bios_from_rom = 1;
        run(20'hFFFF0, 0, "R10", EXP_ROM);
        run(20'hF0000, 1, "R10", EXP_DRAM);
        bios_from_rom = 0;
        run(20'hFFFF0, 0, "R11", EXP_DRAM);
        run(20'hF8000, 1, "R11", EXP_INH);
    endtask

    task automatic t_back_to_back();
        bios_from_rom = 1;
        @(negedge clk); cyc_addr = 20'hF0000; cyc_write = 0; cyc_valid = 1;
        @(negedge clk); check("R2 first", EXP_ROM); cyc_addr = 20'h10000;
        @(negedge clk); check("R2 second", EXP_BUS); cyc_valid = 0;
        @(negedge clk); check("R2 idle after", EXP_NONE);
        @(negedge clk); cyc_valid = 1; cyc_addr = 20'hF0000; rst_n = 0;
        @(negedge clk); check("R1 reset beats valid", EXP_NONE);
        cyc_valid = 0; rst_n = 1; bios_from_rom = 0;
    endtask

    initial begin
        t_reset();
        t_outside();
        t_c_area();
        t_d_area();
        t_e_area();
        t_f_area();
        t_back_to_back();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule